// File: doc/BRIEF.md
# PC Card Socket Adapter Register Interface

This block is the host-facing register file of a PC Card adapter with up to two sockets. The host reaches it through two ports. A write to the index port stores a byte that picks a register. Later accesses through the data port read or write that register. Bit 7 of the index chooses one of two controllers that may share the same port pair, and this instance answers only to its own value of that bit. Bit 6 chooses the socket, and bits 5:0 give the register offset inside that socket's bank.

For each socket the block holds a power control byte, an interrupt and general control byte, a change interrupt configuration byte and a window enable byte, and drives their settings out to the rest of the adapter. A status register reflects the live card detect, battery, write protect, ready and supply inputs. A change register latches insertion, removal and battery events. Reading it returns the events and clears them. Latched events whose enables are set drive a single change interrupt output.

Top module: `pcard_regif`

## Requirements
- R1: Offset 0x00 of either socket reads the constant CHIP_REV (default 0x83; its upper nibble must be 0x8 and its value 0x82 to 0x84). Writes to it have no effect.
- R2: A write on the index port stores the byte. A data access acts only when index bit 7 equals DEV_SEL. Bit 6 selects the socket and bits 5:0 the offset. Read data appears on `rdata` the cycle after `dat_re` and holds until the next read. A read while bit 7 does not match returns 0x00, and a write while it does not match changes nothing.
- R3: Offset 0x01 reads {0, powered, rdy, wp, det[1:0], bvd[1:0]} from the socket's live inputs. Bits 3:2 are both 1 for a fully inserted card. Bits 1:0 are both 1 for a good battery.
- R4: The powered bit is `vcc_ok` AND (power control is nonzero). Writing 0x00 to power control makes it read 0 from the next cycle.
- R5: Offset 0x02 (power control: bit 7 output enable, bit 5 auto power, bit 4 card enable, low bits a supply code of 1 for 5 V and 2 for 12 V) is read/write and appears on `pwr_ctl`.
- R6: Offset 0x03 is read/write. Bit 6 at 0 holds `card_rst_n` low. Bit 5 drives `io_mode`. Bits 3:0 drive `card_irq_num`.
- R7: Offset 0x06 is read/write and appears on `win_en`. Bits 3:0 enable memory windows 0 to 3, and bits 6 and 7 enable I/O windows 0 and 1.
- R8: Offset 0x04 latches events. Bit 3 is set when the inserted condition (both detect bits 1) changes in either direction. Bit 1 is set when `bvd` enters 2'b01 (warning). Bit 0 is set when `bvd[0]` falls to 0 (dead). No event is taken in the first cycle after reset, and writes to 0x04 are ignored.
- R9: A read of 0x04 returns the latched events and clears them at the same edge. An event arriving at that edge stays latched for the next read.
- R10: Offset 0x05 is read/write. Its bit 3 enables change bit 3, bit 1 enables bit 1 and bit 0 enables bit 0. `chg_irq` is the OR over sockets of the enabled latched change bits.
- R11: Offsets 0x07 to 0x3F read 0x00, and writes to them change no register.
- R12: After reset all writable registers are 0x00, `rdata` is 0x00, `card_rst_n` is low and `chg_irq` is low.
- R13: Accesses to one socket's bank leave the other socket's registers and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_we | input | 1 | Write strobe of the index port |
| dat_we | input | 1 | Write strobe of the data port |
| dat_re | input | 1 | Read strobe of the data port |
| wdata | input | 8 | Write byte for both ports |
| rdata | output | 8 | Registered read byte |
| det | input | 2*NSOCK | Two card detect pins per socket, 1 = contact made |
| bvd | input | 2*NSOCK | Two battery condition pins per socket |
| wp | input | NSOCK | Write protect per socket |
| rdy | input | NSOCK | Ready/busy per socket |
| vcc_ok | input | NSOCK | Supply present per socket |
| card_rst_n | output | NSOCK | Card reset, low while held |
| io_mode | output | NSOCK | 1 selects an I/O card |
| card_irq_num | output | 4*NSOCK | Card interrupt routing number per socket |
| pwr_ctl | output | 8*NSOCK | Power control byte per socket |
| win_en | output | 8*NSOCK | Window enable byte per socket |
| chg_irq | output | 1 | Status change interrupt |

## Verification
The status mirror is swept through all 128 input combinations on each socket. This separates any swap or stuck bit among the seven live fields and also shows the powered gating. Every unimplemented offset gets an all-ones write followed by a read, which separates decoding holes from aliasing onto a real register. Change events are raised one kind at a time with masked and unmasked enables, including an event that lands on the same edge as a clearing read. This tells a lost event apart from a failed clear. Accesses with a foreign device bit and with the other socket bit show whether the wrong bank is touched.

// File: rtl/pcard_pkg.sv
package pcard_pkg;

   localparam logic [5:0] OFF_ID     = 6'h00;
   localparam logic [5:0] OFF_STAT   = 6'h01;
   localparam logic [5:0] OFF_PWR    = 6'h02;
   localparam logic [5:0] OFF_IGC    = 6'h03;
   localparam logic [5:0] OFF_CHG    = 6'h04;
   localparam logic [5:0] OFF_CHGCFG = 6'h05;
   localparam logic [5:0] OFF_WIN    = 6'h06;
   localparam logic [5:0] OFF_LAST   = OFF_WIN;

   localparam int CHG_DET  = 3;
   localparam int CHG_WARN = 1;
   localparam int CHG_DEAD = 0;

   localparam int IGC_NRST = 6;
   localparam int IGC_IO   = 5;

   typedef struct packed {
      logic [7:0] pwr;
      logic [7:0] igc;
      logic [7:0] chgcfg;
      logic [7:0] win;
   } sock_regs_t;

endpackage

// File: rtl/pcard_chg_det.sv
module pcard_chg_det
   import pcard_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    det,
   input  logic [1:0]    bvd,
   input  logic          clr,
   output logic [DW-1:0] chg
);

   logic          primed;
   logic          ins_q, warn_q, dead_q;
   logic          ins_now, warn_now, dead_now;
   logic [DW-1:0] ev;

   assign ins_now  = &det;
   assign warn_now = (bvd == 2'b01);
   assign dead_now = ~bvd[0];

   always_comb begin
      ev = '0;
      ev[CHG_DET]  = primed & (ins_now ^ ins_q);
      ev[CHG_WARN] = primed & warn_now & ~warn_q;
      ev[CHG_DEAD] = primed & dead_now & ~dead_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         primed <= 1'b0;
         ins_q  <= 1'b0;
         warn_q <= 1'b0;
         dead_q <= 1'b0;
         chg    <= '0;
      end else begin
         primed <= 1'b1;
         ins_q  <= ins_now;
         warn_q <= warn_now;
         dead_q <= dead_now;
         chg    <= (clr ? '0 : chg) | ev;
      end
   end

   // R9
   chg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && ev == '0) |=> chg == $past(chg));

   // R9
   chg_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && ev == '0) |=> chg == '0);

   // R8
   chg_first_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !primed |=> chg == '0);

endmodule

// File: rtl/pcard_sock_regs.sv
module pcard_sock_regs
   import pcard_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [5:0] off,
   input  logic [7:0] wdata,
   input  logic [1:0] det,
   input  logic [1:0] bvd,
   input  logic       wp,
   input  logic       rdy,
   input  logic       vcc_ok,
   output sock_regs_t regs,
   output logic [7:0] stat
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         regs <= '0;
      end else if (wr_en) begin
         unique case (off)
            OFF_PWR:    regs.pwr    <= wdata;
            OFF_IGC:    regs.igc    <= wdata;
            OFF_CHGCFG: regs.chgcfg <= wdata;
            OFF_WIN:    regs.win    <= wdata;
            default:    ;
         endcase
      end
   end

   assign stat = {1'b0, vcc_ok & (|regs.pwr), rdy, wp, det, bvd};

   // R4
   pwr_off_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && off == OFF_PWR && wdata == 8'h00) |=> !stat[6]);

   // R11
   unimpl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && off > OFF_LAST) |=> regs == $past(regs));

endmodule

// File: rtl/pcard_regif.sv
module pcard_regif
   import pcard_pkg::*;
#(
   parameter int         NSOCK    = 2,
   parameter bit         DEV_SEL  = 1'b0,
   parameter logic [7:0] CHIP_REV = 8'h83
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               idx_we,
   input  logic               dat_we,
   input  logic               dat_re,
   input  logic [7:0]         wdata,
   output logic [7:0]         rdata,
   input  logic [2*NSOCK-1:0] det,
   input  logic [2*NSOCK-1:0] bvd,
   input  logic [NSOCK-1:0]   wp,
   input  logic [NSOCK-1:0]   rdy,
   input  logic [NSOCK-1:0]   vcc_ok,
   output logic [NSOCK-1:0]   card_rst_n,
   output logic [NSOCK-1:0]   io_mode,
   output logic [4*NSOCK-1:0] card_irq_num,
   output logic [8*NSOCK-1:0] pwr_ctl,
   output logic [8*NSOCK-1:0] win_en,
   output logic               chg_irq
);

   localparam int DW = 8;

   if (NSOCK < 1 || NSOCK > 2) begin : g_bad_nsock
      $error("pcard_regif: NSOCK must be 1 or 2");
   end
   if (CHIP_REV[7:4] != 4'h8 || CHIP_REV < 8'h82 || CHIP_REV > 8'h84) begin : g_bad_rev
      $error("pcard_regif: CHIP_REV out of the valid range");
   end

   logic [7:0] idx_q;
   logic       dev_hit;
   logic       sock_sel;
   logic       sock_ok;
   logic [5:0] off;
   logic [7:0] rd_val;

   sock_regs_t        regs [NSOCK];
   logic [DW-1:0]     stat [NSOCK];
   logic [DW-1:0]     chg  [NSOCK];
   logic [NSOCK-1:0]  irq_s;
   logic [NSOCK-1:0]  chg_any;

   assign dev_hit  = (idx_q[7] == DEV_SEL);
   assign sock_sel = idx_q[6];
   assign sock_ok  = (int'(sock_sel) < NSOCK);
   assign off      = idx_q[5:0];

   always_ff @(posedge clk) begin
      if (!rst_n) idx_q <= 8'h00;
      else if (idx_we) idx_q <= wdata;
   end

   for (genvar s = 0; s < NSOCK; s++) begin : g_sock
      logic wr_s, clr_s, hit_s;
      logic [DW-1:0] mask_s;

      assign hit_s = dev_hit && (int'(sock_sel) == s);
      assign wr_s  = dat_we && hit_s;
      assign clr_s = dat_re && hit_s && (off == OFF_CHG);

      pcard_sock_regs i_regs (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_en  (wr_s),
         .off    (off),
         .wdata  (wdata),
         .det    (det[2*s +: 2]),
         .bvd    (bvd[2*s +: 2]),
         .wp     (wp[s]),
         .rdy    (rdy[s]),
         .vcc_ok (vcc_ok[s]),
         .regs   (regs[s]),
         .stat   (stat[s])
      );

      pcard_chg_det #(.DW(DW)) i_chg (
         .clk   (clk),
         .rst_n (rst_n),
         .det   (det[2*s +: 2]),
         .bvd   (bvd[2*s +: 2]),
         .clr   (clr_s),
         .chg   (chg[s])
      );

      always_comb begin
         mask_s = '0;
         mask_s[CHG_DET]  = regs[s].chgcfg[CHG_DET];
         mask_s[CHG_WARN] = regs[s].chgcfg[CHG_WARN];
         mask_s[CHG_DEAD] = regs[s].chgcfg[CHG_DEAD];
      end

      assign irq_s[s]   = |(chg[s] & mask_s);
      assign chg_any[s] = |chg[s];

      assign card_rst_n[s]         = regs[s].igc[IGC_NRST];
      assign io_mode[s]            = regs[s].igc[IGC_IO];
      assign card_irq_num[4*s +: 4] = regs[s].igc[3:0];
      assign pwr_ctl[8*s +: 8]     = regs[s].pwr;
      assign win_en[8*s +: 8]      = regs[s].win;
   end

   assign chg_irq = |irq_s;

   always_comb begin
      rd_val = 8'h00;
      if (dev_hit && sock_ok) begin
         unique case (off)
            OFF_ID:     rd_val = CHIP_REV;
            OFF_STAT:   rd_val = stat[sock_sel ? NSOCK-1 : 0];
            OFF_PWR:    rd_val = regs[sock_sel ? NSOCK-1 : 0].pwr;
            OFF_IGC:    rd_val = regs[sock_sel ? NSOCK-1 : 0].igc;
            OFF_CHG:    rd_val = chg[sock_sel ? NSOCK-1 : 0];
            OFF_CHGCFG: rd_val = regs[sock_sel ? NSOCK-1 : 0].chgcfg;
            OFF_WIN:    rd_val = regs[sock_sel ? NSOCK-1 : 0].win;
            default:    rd_val = 8'h00;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rdata <= 8'h00;
      else if (dat_re) rdata <= rd_val;
   end

   // R11
   unimpl_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_re && off > OFF_LAST) |=> rdata == 8'h00);

   // R2
   foreign_dev_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_re && !dev_hit) |=> rdata == 8'h00);

   // R2
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dat_re |=> $stable(rdata));

   // R10
   irq_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chg_irq |-> (|chg_any));

   // R1
   id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_re && dev_hit && sock_ok && off == OFF_ID) |=> rdata == CHIP_REV);

endmodule

// File: tb/test_pcard_regif.sv
module test_pcard_regif;

   localparam int NS = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          idx_we = 1'b0, dat_we = 1'b0, dat_re = 1'b0;
   logic [7:0]    wdata = 8'h00;
   logic [7:0]    rdata;
   logic [2*NS-1:0] det = '0, bvd = '1;
   logic [NS-1:0] wp = '0, rdy = '0, vcc_ok = '0;
   logic [NS-1:0] card_rst_n, io_mode;
   logic [4*NS-1:0] card_irq_num;
   logic [8*NS-1:0] pwr_ctl, win_en;
   logic          chg_irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pcard_regif i_pcard_regif (
      .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .dat_we(dat_we), .dat_re(dat_re),
      .wdata(wdata), .rdata(rdata), .det(det), .bvd(bvd), .wp(wp), .rdy(rdy),
      .vcc_ok(vcc_ok), .card_rst_n(card_rst_n), .io_mode(io_mode),
      .card_irq_num(card_irq_num), .pwr_ctl(pwr_ctl), .win_en(win_en),
      .chg_irq(chg_irq)
   );

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic set_idx(input logic [7:0] v);
      @(negedge clk); idx_we = 1'b1; wdata = v;
      @(negedge clk); idx_we = 1'b0;
   endtask

   task automatic wr(input logic [7:0] v);
      @(negedge clk); dat_we = 1'b1; wdata = v;
      @(negedge clk); dat_we = 1'b0;
   endtask

   task automatic rd(output logic [7:0] v);
      @(negedge clk); dat_re = 1'b1;
      @(negedge clk); dat_re = 1'b0; v = rdata;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      logic [7:0] pv [6];
      pv[0] = 8'h00; pv[1] = 8'h01; pv[2] = 8'h02;
      pv[3] = 8'h90; pv[4] = 8'hB1; pv[5] = 8'hFF;

      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 rdata", {8'h0, rdata}, 16'h0);
      chk("R12 chg_irq", {15'h0, chg_irq}, 16'h0);
      chk("R12 card_rst_n", {14'h0, card_rst_n}, 16'h0);
      chk("R12 pwr_ctl", pwr_ctl, 16'h0);
      chk("R12 win_en", win_en, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 identification
      set_idx(8'h00); rd(v); chk("R1 id s0", {8'h0, v}, 16'h0083);
      wr(8'h55); rd(v); chk("R1 id after write", {8'h0, v}, 16'h0083);
      set_idx(8'h40); rd(v); chk("R1 id s1", {8'h0, v}, 16'h0083);

      // R5 power control sweep on socket 0, R13 socket 1 untouched
      set_idx(8'h02);
      for (int i = 0; i < 6; i++) begin
         wr(pv[i]);
         chk("R5 pwr_ctl port", {8'h0, pwr_ctl[7:0]}, {8'h0, pv[i]});
         chk("R13 pwr_ctl s1", {8'h0, pwr_ctl[15:8]}, 16'h0);
         rd(v); chk("R5 pwr readback", {8'h0, v}, {8'h0, pv[i]});
      end

      // R6 interrupt/general control on socket 1
      set_idx(8'h43); wr(8'h6A);
      chk("R6 card_rst_n s1", {15'h0, card_rst_n[1]}, 16'h1);
      chk("R6 io_mode s1", {15'h0, io_mode[1]}, 16'h1);
      chk("R6 irq num s1", {12'h0, card_irq_num[7:4]}, 16'hA);
      chk("R13 card_rst_n s0", {15'h0, card_rst_n[0]}, 16'h0);
      rd(v); chk("R6 igc readback", {8'h0, v}, 16'h006A);
      wr(8'h05);
      chk("R6 reset held", {15'h0, card_rst_n[1]}, 16'h0);
      chk("R6 io_mode off", {15'h0, io_mode[1]}, 16'h0);

      // R7 window enable
      set_idx(8'h06); wr(8'hCF);
      chk("R7 win_en s0", {8'h0, win_en[7:0]}, 16'h00CF);
      chk("R13 win_en s1", {8'h0, win_en[15:8]}, 16'h0);
      rd(v); chk("R7 win readback", {8'h0, v}, 16'h00CF);

      // R11 unimplemented offsets
      for (int o = 7; o < 64; o++) begin
         set_idx(8'(o)); wr(8'hFF); rd(v);
         chk("R11 unimpl read", {8'h0, v}, 16'h0);
      end
      chk("R11 pwr intact", pwr_ctl, 16'h00FF);
      chk("R11 win intact", win_en, 16'h00CF);

      // R2 foreign device bit
      set_idx(8'h82); wr(8'h11); rd(v);
      chk("R2 foreign read", {8'h0, v}, 16'h0);
      chk("R2 foreign write", pwr_ctl, 16'h00FF);
      set_idx(8'h02); rd(v);
      chk("R2 own read", {8'h0, v}, 16'h00FF);

      // R3 status mirror sweep on both sockets
      set_idx(8'h42); wr(8'h90);
      set_idx(8'h02); wr(8'h90);
      for (int s = 0; s < NS; s++) begin
         set_idx(8'((s << 6) | 1));
         for (int p = 0; p < 128; p++) begin
            bvd[2*s +: 2] = 2'(p);
            det[2*s +: 2] = 2'(p >> 2);
            wp[s] = p[4]; rdy[s] = p[5]; vcc_ok[s] = p[6];
            rd(v);
            chk("R3 status", {8'h0, v}, 16'(p & 8'h7F));
         end
      end

      // settle inputs, drain change registers
      det = '0; bvd = '1; wp = '0; rdy = '0; vcc_ok = '0;
      repeat (2) @(negedge clk);
      set_idx(8'h04); rd(v); rd(v);
      chk("R9 s0 drained", {8'h0, v}, 16'h0);
      set_idx(8'h44); rd(v); rd(v);
      chk("R9 s1 drained", {8'h0, v}, 16'h0);

      // R4 powered flag
      vcc_ok[0] = 1'b1;
      set_idx(8'h01); rd(v);
      chk("R4 powered on", {8'h0, v}, 16'h0043);
      set_idx(8'h02); wr(8'h00);
      set_idx(8'h01); rd(v);
      chk("R4 powered cleared", {8'h0, v}, 16'h0003);

      // R8 / R10 insertion event with enable
      set_idx(8'h05); wr(8'h08);
      chk("R10 idle irq", {15'h0, chg_irq}, 16'h0);
      det[1:0] = 2'b11; @(negedge clk);
      chk("R10 irq on insert", {15'h0, chg_irq}, 16'h1);
      set_idx(8'h04); rd(v);
      chk("R8 insert event", {8'h0, v}, 16'h0008);
      chk("R9 irq after clear", {15'h0, chg_irq}, 16'h0);
      rd(v); chk("R9 cleared", {8'h0, v}, 16'h0);

      // R8 warning event, masked
      bvd[1:0] = 2'b01; @(negedge clk);
      chk("R10 masked warn", {15'h0, chg_irq}, 16'h0);
      // R9 event at the clearing edge survives
      det[1:0] = 2'b00; dat_re = 1'b1;
      @(negedge clk); dat_re = 1'b0; v = rdata;
      chk("R9 read with new event", {8'h0, v}, 16'h0002);
      chk("R10 irq on removal", {15'h0, chg_irq}, 16'h1);
      rd(v); chk("R9 event kept", {8'h0, v}, 16'h0008);

      // R8 dead battery event, enabled
      set_idx(8'h05); wr(8'h01);
      bvd[1:0] = 2'b00; @(negedge clk);
      chk("R10 irq dead", {15'h0, chg_irq}, 16'h1);
      set_idx(8'h04); rd(v);
      chk("R8 dead event", {8'h0, v}, 16'h0001);

      // R13 socket 1 events
      set_idx(8'h45); wr(8'h08);
      det[3:2] = 2'b11; @(negedge clk);
      chk("R13 irq s1", {15'h0, chg_irq}, 16'h1);
      set_idx(8'h04); rd(v);
      chk("R13 s0 untouched", {8'h0, v}, 16'h0);
      set_idx(8'h44); rd(v);
      chk("R13 s1 event", {8'h0, v}, 16'h0008);

      // R8 write to change register ignored
      det[3:2] = 2'b00; @(negedge clk);
      wr(8'h00); rd(v);
      chk("R8 write ignored", {8'h0, v}, 16'h0008);

      // R10 config readback
      set_idx(8'h45); wr(8'hF8); rd(v);
      chk("R10 cfg readback", {8'h0, v}, 16'h00F8);

      finish_run();
   end

endmodule